// File: doc/BRIEF.md
# Single-Wire RGB LED Pulse Encoder

This block drives one addressable RGB LED over a single data line that has no companion clock. A 24-bit colour word (three 8-bit channel intensities) is accepted on a valid/ready handshake. Each bit goes out as a high pulse followed by a low gap. The value of the bit is carried only by how long each phase lasts: a short high with a long low is a zero, and a long high with a short low is a one.

The line idles low. After the last bit of a word, the encoder holds the line low for a latch interval longer than 280 µs, so that the LED takes up the new colour. Only after that interval does it accept another word. Every duration is given in nanoseconds and turned into a whole number of cycles of the system clock, whose frequency is a parameter.

Top module: `rgb_pulse_tx`

## Requirements
- R1: `in_ready` is high only while the encoder is idle. A word is taken in the cycle where `in_valid` and `in_ready` are both high. While a frame is in progress, `in_valid` and `in_word` have no effect, and no second frame follows the current one.
- R2: A zero bit drives the line high for round(300 ns × CLK_HZ) cycles and then low for round(850 ns × CLK_HZ) cycles. Rounding is to the nearest cycle, with halves rounded up.
- R3: A one bit drives the line high for round(800 ns × CLK_HZ) cycles and then low for round(400 ns × CLK_HZ) cycles.
- R4: Bits leave least significant first. Bit 0 of `in_word` is the first pulse and bit 23 is the last.
- R5: Each accepted word produces exactly 24 high pulses.
- R6: After the final high pulse, the line stays low for that bit's low time plus round(GAP_NS × CLK_HZ) cycles. GAP_NS defaults to 290 000 ns. `in_ready` returns in the cycle after this low stretch ends.
- R7: `busy` goes high in the cycle after capture and stays high until the latch interval ends. At all times it is the inverse of `in_ready`.
- R8: A synchronous active-high `rst` drives the line low, `busy` low and `in_ready` high on the next edge. Any frame in progress is dropped and never resumes.
- R9: The line is low while idle. It goes high in the cycle after a word is captured, and it rises only at the start of a bit's high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A colour word is offered |
| in_ready | output | 1 | Encoder is idle and can take a word |
| in_word | input | BITS | Colour word; bit 0 is sent first |
| busy | output | 1 | A frame or its latch interval is in progress |
| led_dout | output | 1 | Serial line to the LED |

## Verification
The bench measures every high and low run on the line in cycles and compares each one against the counts for a zero or a one. A design that rounds 850 ns down, or that swaps which phase is the long one, gives a low or high run one cycle or many cycles off. The bench rebuilds each word from the pulse widths, so sending most significant bit first or dropping a bit shows up as a word mismatch or a pulse count other than 24. It also checks that the low run after the final bit equals that bit's low time plus the latch interval; an encoder that skips or shortens the latch gap raises `in_ready` too early. It drives `in_valid` with a different word while a frame is running, and it resets in the middle of a frame. These two tests catch an encoder that accepts a second word while busy, or one that keeps pulsing after reset.

// File: rtl/rgb_pulse_pkg.sv
package rgb_pulse_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2,
    ST_GAP  = 2'd3
  } tx_state_e;

  // Nearest whole cycle count for a duration in ns; halves round up.
  function automatic int ns_to_cycles(input longint clk_hz, input longint dur_ns);
    longint prod;
    prod = dur_ns * clk_hz + 64'sd500_000_000;
    return int'(prod / 64'sd1_000_000_000);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rgb_phase_timer.sv
module rgb_phase_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R6: without a reload the remaining time only shrinks
  property cnt_monotonic_p;
    @(posedge clk) disable iff (rst)
      !load |=> (cnt_q <= $past(cnt_q));
  endproperty
  cnt_monotonic_chk: assert property (cnt_monotonic_p);

endmodule

// File: rtl/rgb_bit_shifter.sv
module rgb_bit_shifter #(
  parameter int BITS = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic [BITS-1:0] load_word,
  output logic            cur_bit,
  output logic            next_bit,
  output logic            last_bit
);

  localparam int IDX_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITS - 1);

  logic [BITS-1:0]  word_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      word_q <= load_word;
      idx_q  <= '0;
    end else if (shift) begin
      word_q <= {1'b0, word_q[BITS-1:1]};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = word_q[0];
  assign last_bit = (idx_q == LAST_IDX);

  generate
    if (BITS > 1) begin : g_next
      assign next_bit = word_q[1];
    end else begin : g_single
      assign next_bit = 1'b0;
    end
  endgenerate

  // R5: the bit index never runs past the last bit of the frame
  property idx_range_p;
    @(posedge clk) disable iff (rst)
      shift |-> (idx_q < LAST_IDX);
  endproperty
  idx_range_chk: assert property (idx_range_p);

endmodule

// File: rtl/rgb_pulse_tx.sv
module rgb_pulse_tx
  import rgb_pulse_pkg::*;
#(
  parameter longint CLK_HZ = 200_000_000,
  parameter int     BITS   = 24,
  parameter int     T0H_NS = 300,
  parameter int     T0L_NS = 850,
  parameter int     T1H_NS = 800,
  parameter int     T1L_NS = 400,
  parameter int     GAP_NS = 290_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [BITS-1:0] in_word,
  output logic            busy,
  output logic            led_dout
);

  localparam int C0H  = ns_to_cycles(CLK_HZ, longint'(T0H_NS));
  localparam int C0L  = ns_to_cycles(CLK_HZ, longint'(T0L_NS));
  localparam int C1H  = ns_to_cycles(CLK_HZ, longint'(T1H_NS));
  localparam int C1L  = ns_to_cycles(CLK_HZ, longint'(T1L_NS));
  localparam int CGAP = ns_to_cycles(CLK_HZ, longint'(GAP_NS));
  localparam int CMAX = max2(max2(max2(C0H, C0L), max2(C1H, C1L)), CGAP);
  localparam int CNT_W = $clog2(CMAX + 1);

  localparam logic [CNT_W-1:0] LD0H = CNT_W'(C0H - 1);
  localparam logic [CNT_W-1:0] LD0L = CNT_W'(C0L - 1);
  localparam logic [CNT_W-1:0] LD1H = CNT_W'(C1H - 1);
  localparam logic [CNT_W-1:0] LD1L = CNT_W'(C1L - 1);
  localparam logic [CNT_W-1:0] LDGP = CNT_W'(CGAP - 1);

  tx_state_e        state_q, state_d;
  logic             dout_d;
  logic             t_load;
  logic [CNT_W-1:0] t_val;
  logic             t_expired;
  logic             s_load, s_shift;
  logic             cur_bit, next_bit, last_bit;
  logic             capture;

  assign capture = in_valid && (state_q == ST_IDLE);

  rgb_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  rgb_bit_shifter #(.BITS(BITS)) shifter_i (
    .clk       (clk),
    .rst       (rst),
    .load      (s_load),
    .shift     (s_shift),
    .load_word (in_word),
    .cur_bit   (cur_bit),
    .next_bit  (next_bit),
    .last_bit  (last_bit)
  );

  always_comb begin
    state_d = state_q;
    dout_d  = led_dout;
    t_load  = 1'b0;
    t_val   = '0;
    s_load  = 1'b0;
    s_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (capture) begin
          state_d = ST_HIGH;
          dout_d  = 1'b1;
          t_load  = 1'b1;
          t_val   = in_word[0] ? LD1H : LD0H;
          s_load  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (t_expired) begin
          state_d = ST_LOW;
          dout_d  = 1'b0;
          t_load  = 1'b1;
          t_val   = cur_bit ? LD1L : LD0L;
        end
      end
      ST_LOW: begin
        if (t_expired) begin
          t_load = 1'b1;
          if (last_bit) begin
            state_d = ST_GAP;
            t_val   = LDGP;
          end else begin
            state_d = ST_HIGH;
            dout_d  = 1'b1;
            s_shift = 1'b1;
            t_val   = next_bit ? LD1H : LD0H;
          end
        end
      end
      ST_GAP: begin
        if (t_expired) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      led_dout <= 1'b0;
      in_ready <= 1'b1;
      busy     <= 1'b0;
    end else begin
      state_q  <= state_d;
      led_dout <= dout_d;
      in_ready <= (state_d == ST_IDLE);
      busy     <= (state_d != ST_IDLE);
    end
  end

  // R9
  property capture_line_high_p;
    @(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> led_dout;
  endproperty
  capture_line_high_chk: assert property (capture_line_high_p);

  // R8
  property reset_idle_p;
    @(posedge clk) rst |=> (!led_dout && in_ready && !busy);
  endproperty
  reset_idle_chk: assert property (reset_idle_p);

  // R7
  property ready_busy_excl_p;
    @(posedge clk) disable iff (rst)
      in_ready != busy;
  endproperty
  ready_busy_excl_chk: assert property (ready_busy_excl_p);

  // R1
  property rise_only_busy_p;
    @(posedge clk) disable iff (rst)
      $rose(led_dout) |-> !in_ready;
  endproperty
  rise_only_busy_chk: assert property (rise_only_busy_p);

  // R6
  property gap_low_p;
    @(posedge clk) disable iff (rst)
      (state_q == ST_GAP) |-> !led_dout;
  endproperty
  gap_low_chk: assert property (gap_low_p);

endmodule

// File: tb/rgb_pulse_tx_tb_top.sv
module rgb_pulse_tx_tb_top;

  localparam longint CLK_HZ = 50_000_000;
  localparam int     BITS   = 24;
  // expected durations: nearest cycle, halves up, at 50 MHz (20 ns)
  localparam int E0H  = (300 * 50 + 500) / 1000;      // 15
  localparam int E0L  = (850 * 50 + 500) / 1000;      // 43
  localparam int E1H  = (800 * 50 + 500) / 1000;      // 40
  localparam int E1L  = (400 * 50 + 500) / 1000;      // 20
  localparam int EGAP = (290_000 * 50 + 500) / 1000;  // 14500

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [BITS-1:0] in_word = '0;
  logic in_ready, busy, led_dout;

  int checks = 0;
  int errors = 0;
  logic [BITS-1:0] exp_q[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rgb_pulse_tx #(.CLK_HZ(CLK_HZ), .BITS(BITS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .busy(busy), .led_dout(led_dout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  int hcnt = 0, lcnt = 0, nbits = 0;
  logic [BITS-1:0] got = '0;
  bit active = 1'b0;
  logic prev = 1'b0;

  task automatic mon_clear();
    hcnt = 0; lcnt = 0; nbits = 0; got = '0; active = 1'b0; prev = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (led_dout) begin
        if (!prev) begin
          if (nbits > 0) begin
            if (got[nbits-1]) check(lcnt == E1L, "R3 low", lcnt, E1L);
            else              check(lcnt == E0L, "R2 low", lcnt, E0L);
          end
          hcnt = 1; lcnt = 0; active = 1'b1;
        end else begin
          hcnt++;
        end
      end else begin
        if (prev) begin
          check(hcnt == E0H || hcnt == E1H, "R2/R3 high", hcnt, E1H);
          if (nbits < BITS) got[nbits] = (hcnt == E1H);
          nbits++;
          lcnt = 1;
        end else if (active && in_ready) begin
          logic [BITS-1:0] exp_w;
          int exp_l;
          exp_l = (got[BITS-1] ? E1L : E0L) + EGAP;
          check(nbits == BITS, "R5 pulses", nbits, BITS);
          check(lcnt == exp_l, "R6 gap", lcnt, exp_l);
          check(!busy, "R7 busy end", int'(busy), 0);
          if (exp_q.size() == 0) begin
            check(1'b0, "R1 unexpected frame", int'(got), 0);
          end else begin
            exp_w = exp_q.pop_front();
            check(got == exp_w, "R4 word", int'(got), int'(exp_w));
          end
          hcnt = 0; lcnt = 0; nbits = 0; got = '0; active = 1'b0;
        end else begin
          lcnt++;
        end
      end
      prev = led_dout;
    end
  end

  task automatic send(input logic [BITS-1:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    exp_q.push_back(w);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    check(led_dout == 1'b1, "R9 first rise", int'(led_dout), 1);
    check(busy == 1'b1, "R7 busy after capture", int'(busy), 1);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0 || !in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(led_dout == 1'b0, "R8 reset line", int'(led_dout), 0);
    check(in_ready == 1'b1, "R8 reset ready", int'(in_ready), 1);
    check(busy == 1'b0, "R8 reset busy", int'(busy), 0);
    repeat (5) @(negedge clk);
    check(led_dout == 1'b0, "R9 idle low", int'(led_dout), 0);
    mon_en = 1'b1;

    send(24'h000000); wait_idle();
    send(24'hFFFFFF); wait_idle();
    send(24'hA5C31E); wait_idle();

    // R1: valid with another word while busy is ignored
    send(24'h000001);
    repeat (10) @(negedge clk);
    in_valid = 1'b1; in_word = 24'h7E7E7E;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 20) check(in_ready == 1'b0, "R1 ready low busy", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    wait_idle();
    repeat (30) @(negedge clk);
    check(led_dout == 1'b0 && in_ready, "R1 no second frame", int'(led_dout), 0);

    // R8: reset in mid frame drops it
    send(24'h5A5A5A);
    repeat (300) @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    void'(exp_q.pop_front());
    mon_clear();
    check(led_dout == 1'b0, "R8 abort line", int'(led_dout), 0);
    check(in_ready == 1'b1, "R8 abort ready", int'(in_ready), 1);
    begin
      int highs = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (led_dout) highs++;
      end
      check(highs == 0, "R8 no resume", highs, 0);
    end
    mon_en = 1'b1;

    send(24'h800000); wait_idle();
    check(exp_q.size() == 0, "R5 all frames seen", exp_q.size(), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule